// File: doc/BRIEF.md
# SRAM Data-Pattern Test Sequencer

This block runs a fixed data-background test on a single-port, 32-bit-wide SRAM. It checks the array for bit cells that do not hold their value, and it keeps a count of the errors. A single start pulse begins a test. For each of seven background words, the sequencer first fills a 16-word address window with that word. It then reads every location in the window twice and compares each returned word with the word it wrote.

The whole set of seven backgrounds is repeated over three runs, and a separate mismatch counter is kept for each run. Failures caused by weak supply or marginal noise tend to come and go. Comparing the three run counts shows whether a failure repeats or appears only once.

The memory drives its read data from the falling clock edge. The sequencer therefore spends one full cycle waiting on each read before it compares the result. The first mismatch of a test is captured with its address, background index, run index and returned word. A sticky fail flag, a one-cycle done pulse and the per-run counters give the result at the end of the test.

Top module: `sram_pattern_tester`

## Requirements
- R1: After reset, chip enable, write enable, busy, done, fail and first-valid are all low, and every per-run counter reads zero.
- R2: A start is accepted only while busy is low. A start raised during a test does not change the command stream or the time at which done arrives.
- R3: For each background, the block issues 16 write commands first, one per cycle, to addresses BASE..BASE+15 in ascending order (chip enable and write enable both high), before any read of that background.
- R4: The backgrounds are used in index order 0 to 6, with the values 0x55555555, 0x33333333, 0x0F0F0F0F, 0x00FF00FF, 0x0000FFFF, 0xFFFFFFFF and 0x00000000. The reported pattern index uses this numbering.
- R5: After the writes, each address is read twice in a row, in ascending address order. Each read command cycle is followed by one cycle with chip enable low. The read data is sampled at the clock edge that ends that following cycle.
- R6: The background set is repeated for 3 runs. Done is high for exactly one cycle, 1704 clock edges after the edge that accepted the start, and busy falls on the next cycle.
- R7: Each run has its own 16-bit mismatch counter. The counter for run r sits at bits [16r+15:16r] of the counter bus. Every mismatching read adds one. The counters hold their values after done and are cleared on the edge that accepts a start.
- R8: The fail flag is set by the first mismatch. It stays high until a start is accepted, and it is high exactly when some run counter is non-zero.
- R9: On the first mismatch of a test, the block latches the address, background index, run index (0 to 2) and returned word, and raises first-valid. Later mismatches do not overwrite these values, and an accepted start clears first-valid.
- R10: The window base is a parameter. Elaboration rejects any window that would pass the last address (511 for a 9-bit address), and every command address lies inside the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begins a test when idle |
| mem_ce_o | output | 1 | SRAM chip enable |
| mem_we_o | output | 1 | SRAM write enable (high means write) |
| mem_addr_o | output | 9 | SRAM word address |
| mem_wdata_o | output | 32 | SRAM write data |
| mem_rdata_i | input | 32 | SRAM read data, launched on the falling edge |
| busy_o | output | 1 | Test in progress, including the done cycle |
| done_o | output | 1 | One-cycle pulse at the end of the test |
| fail_o | output | 1 | Sticky mismatch flag |
| err_cnt_o | output | 48 | Per-run mismatch counters, run r at bits [16r+15:16r] |
| first_valid_o | output | 1 | First-failure record is valid |
| first_addr_o | output | 9 | Address of the first mismatch |
| first_pat_o | output | 3 | Background index of the first mismatch |
| first_run_o | output | 2 | Run index of the first mismatch |
| first_data_o | output | 32 | Word returned by the first mismatching read |

## Verification
A wrong step in the sequence state or the address counter shows on the command pins at once. The bench compares chip enable, write enable, address and write data in every cycle of a complete test, so such a fault appears within one cycle. A comparator that samples on the wrong edge sees the filler word the memory model drives outside valid data, so the counters become non-zero and fail is raised by the end of the first background. A fault in the run index or in the first-failure capture shows only in the results. For this reason the bench injects a stuck bit that fails in every run and a single flipped read in one chosen run, and it checks the per-run counts and the latched record after done.

// File: rtl/srpt_pkg.sv
package srpt_pkg;
   localparam int PAT_COUNT = 7;
   localparam int PAT_IDX_W = 3;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WRITE,
      ST_READ,
      ST_CHECK,
      ST_NEXT_PAT,
      ST_NEXT_RUN,
      ST_DONE
   } seq_state_e;
endpackage

// File: rtl/srpt_sequencer.sv
module srpt_sequencer
   import srpt_pkg::*;
#(
   parameter int ADDR_W         = 9,
   parameter int DATA_W         = 32,
   parameter int BASE_ADDR      = 0,
   parameter int WIN_DEPTH      = 16,
   parameter int READS_PER_WORD = 2,
   parameter int NUM_RUNS       = 3,
   localparam int RUN_W         = (NUM_RUNS > 1) ? $clog2(NUM_RUNS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   output logic                 mem_ce_o,
   output logic                 mem_we_o,
   output logic [ADDR_W-1:0]    mem_addr_o,
   output logic [DATA_W-1:0]    mem_wdata_o,
   output logic                 busy_o,
   output logic                 done_o,
   output logic                 clr_o,
   output logic                 chk_valid_o,
   output logic [DATA_W-1:0]    exp_o,
   output logic [PAT_IDX_W-1:0] pat_o,
   output logic [RUN_W-1:0]     run_o
);
   localparam int WIN_W = (WIN_DEPTH > 1) ? $clog2(WIN_DEPTH) : 1;
   localparam int REP_W = (READS_PER_WORD > 1) ? $clog2(READS_PER_WORD) : 1;
   localparam logic [WIN_W-1:0]     LAST_WORD = WIN_W'(WIN_DEPTH - 1);
   localparam logic [REP_W-1:0]     LAST_REP  = REP_W'(READS_PER_WORD - 1);
   localparam logic [RUN_W-1:0]     LAST_RUN  = RUN_W'(NUM_RUNS - 1);
   localparam logic [PAT_IDX_W-1:0] LAST_PAT  = PAT_IDX_W'(PAT_COUNT - 1);
   localparam logic [ADDR_W-1:0]    WIN_LO    = ADDR_W'(BASE_ADDR);
   localparam logic [ADDR_W-1:0]    WIN_HI    = ADDR_W'(BASE_ADDR + WIN_DEPTH - 1);

   seq_state_e           state_q;
   logic [WIN_W-1:0]     word_q;
   logic [REP_W-1:0]     rep_q;
   logic [PAT_IDX_W-1:0] pat_q;
   logic [RUN_W-1:0]     run_q;

   // Indices 0..4 are stripes of width 1,2,4,8,16 with the low stripe set;
   // index 5 is all ones, anything above is all zeros.
   function automatic logic [DATA_W-1:0] background(input logic [PAT_IDX_W-1:0] idx);
      logic [DATA_W-1:0] w;
      w = '0;
      if (idx == PAT_IDX_W'(5)) begin
         w = '1;
      end else if (idx < PAT_IDX_W'(5)) begin
         for (int i = 0; i < DATA_W; i++) begin
            w[i] = (((i >> idx) & 1) == 0);
         end
      end
      return w;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         word_q  <= '0;
         rep_q   <= '0;
         pat_q   <= '0;
         run_q   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  state_q <= ST_WRITE;
                  word_q  <= '0;
                  rep_q   <= '0;
                  pat_q   <= '0;
                  run_q   <= '0;
               end
            end
            ST_WRITE: begin
               if (word_q == LAST_WORD) begin
                  word_q  <= '0;
                  state_q <= ST_READ;
               end else begin
                  word_q <= word_q + 1'b1;
               end
            end
            ST_READ: state_q <= ST_CHECK;
            ST_CHECK: begin
               state_q <= ST_READ;
               if (rep_q == LAST_REP) begin
                  rep_q <= '0;
                  if (word_q == LAST_WORD) begin
                     word_q  <= '0;
                     state_q <= ST_NEXT_PAT;
                  end else begin
                     word_q <= word_q + 1'b1;
                  end
               end else begin
                  rep_q <= rep_q + 1'b1;
               end
            end
            ST_NEXT_PAT: begin
               if (pat_q == LAST_PAT) begin
                  pat_q   <= '0;
                  state_q <= ST_NEXT_RUN;
               end else begin
                  pat_q   <= pat_q + 1'b1;
                  state_q <= ST_WRITE;
               end
            end
            ST_NEXT_RUN: begin
               if (run_q == LAST_RUN) begin
                  state_q <= ST_DONE;
               end else begin
                  run_q   <= run_q + 1'b1;
                  state_q <= ST_WRITE;
               end
            end
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_ce_o    = (state_q == ST_WRITE) || (state_q == ST_READ);
   assign mem_we_o    = (state_q == ST_WRITE);
   assign mem_addr_o  = WIN_LO + ADDR_W'(word_q);
   assign exp_o       = background(pat_q);
   assign mem_wdata_o = exp_o;
   assign busy_o      = (state_q != ST_IDLE);
   assign done_o      = (state_q == ST_DONE);
   assign clr_o       = start_i && (state_q == ST_IDLE);
   assign chk_valid_o = (state_q == ST_CHECK);
   assign pat_o       = pat_q;
   assign run_o       = run_q;

   AST_ADDR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      mem_ce_o |-> (mem_addr_o >= WIN_LO) && (mem_addr_o <= WIN_HI)); // R10
   AST_CHECK_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_CHECK) |-> $past(mem_ce_o && !mem_we_o)); // R5
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R6
   AST_RUN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_NEXT_RUN) && !clr_o |=> $stable(run_q)); // R6
   AST_PAT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      pat_q <= LAST_PAT); // R4
endmodule

// File: rtl/srpt_checker.sv
module srpt_checker
   import srpt_pkg::*;
#(
   parameter int ADDR_W   = 9,
   parameter int DATA_W   = 32,
   parameter int NUM_RUNS = 3,
   parameter int CNT_W    = 16,
   localparam int RUN_W   = (NUM_RUNS > 1) ? $clog2(NUM_RUNS) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clr_i,
   input  logic                      chk_valid_i,
   input  logic [DATA_W-1:0]         exp_i,
   input  logic [DATA_W-1:0]         rdata_i,
   input  logic [ADDR_W-1:0]         addr_i,
   input  logic [PAT_IDX_W-1:0]      pat_i,
   input  logic [RUN_W-1:0]          run_i,
   output logic [NUM_RUNS*CNT_W-1:0] err_cnt_o,
   output logic                      fail_o,
   output logic                      first_valid_o,
   output logic [ADDR_W-1:0]         first_addr_o,
   output logic [PAT_IDX_W-1:0]      first_pat_o,
   output logic [RUN_W-1:0]          first_run_o,
   output logic [DATA_W-1:0]         first_data_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic miss;
   assign miss = chk_valid_i && (rdata_i != exp_i);

   for (genvar r = 0; r < NUM_RUNS; r++) begin : g_run_cnt
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (clr_i) begin
            cnt_q <= '0;
         end else if (miss && (run_i == RUN_W'(r)) && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
      assign err_cnt_o[r*CNT_W +: CNT_W] = cnt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fail_o        <= 1'b0;
         first_valid_o <= 1'b0;
         first_addr_o  <= '0;
         first_pat_o   <= '0;
         first_run_o   <= '0;
         first_data_o  <= '0;
      end else if (clr_i) begin
         fail_o        <= 1'b0;
         first_valid_o <= 1'b0;
      end else if (miss) begin
         fail_o <= 1'b1;
         if (!first_valid_o) begin
            first_valid_o <= 1'b1;
            first_addr_o  <= addr_i;
            first_pat_o   <= pat_i;
            first_run_o   <= run_i;
            first_data_o  <= rdata_i;
         end
      end
   end

   AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      fail_o && !clr_i |=> fail_o); // R8
   AST_FAIL_MATCHES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      fail_o == (err_cnt_o != '0)); // R8
   AST_MISS_SETS_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
      miss && !clr_i |=> fail_o); // R8
   AST_FIRST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      first_valid_o && !clr_i |=> first_valid_o && $stable(first_addr_o)
                                  && $stable(first_pat_o) && $stable(first_run_o)
                                  && $stable(first_data_o)); // R9
endmodule

// File: rtl/sram_pattern_tester.sv
module sram_pattern_tester
   import srpt_pkg::*;
#(
   parameter int ADDR_W         = 9,
   parameter int DATA_W         = 32,
   parameter int BASE_ADDR      = 0,
   parameter int WIN_DEPTH      = 16,
   parameter int READS_PER_WORD = 2,
   parameter int NUM_RUNS       = 3,
   parameter int CNT_W          = 16,
   localparam int RUN_W         = (NUM_RUNS > 1) ? $clog2(NUM_RUNS) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start_i,
   output logic                      mem_ce_o,
   output logic                      mem_we_o,
   output logic [ADDR_W-1:0]         mem_addr_o,
   output logic [DATA_W-1:0]         mem_wdata_o,
   input  logic [DATA_W-1:0]         mem_rdata_i,
   output logic                      busy_o,
   output logic                      done_o,
   output logic                      fail_o,
   output logic [NUM_RUNS*CNT_W-1:0] err_cnt_o,
   output logic                      first_valid_o,
   output logic [ADDR_W-1:0]         first_addr_o,
   output logic [PAT_IDX_W-1:0]      first_pat_o,
   output logic [RUN_W-1:0]          first_run_o,
   output logic [DATA_W-1:0]         first_data_o
);
   initial begin
      AST_WINDOW_FITS: assert (BASE_ADDR >= 0 && BASE_ADDR + WIN_DEPTH <= (1 << ADDR_W))
         else $error("test window passes the last address"); // R10
      AST_PARAMS_SANE: assert (WIN_DEPTH >= 2 && READS_PER_WORD >= 1 && NUM_RUNS >= 1
                               && CNT_W >= 1 && DATA_W >= 32)
         else $error("illegal sequencer parameters"); // R10
   end

   logic                 clr;
   logic                 chk_valid;
   logic [DATA_W-1:0]    exp_word;
   logic [PAT_IDX_W-1:0] cur_pat;
   logic [RUN_W-1:0]     cur_run;

   srpt_sequencer #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR),
      .WIN_DEPTH(WIN_DEPTH), .READS_PER_WORD(READS_PER_WORD), .NUM_RUNS(NUM_RUNS)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .mem_ce_o(mem_ce_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
      .mem_wdata_o(mem_wdata_o), .busy_o(busy_o), .done_o(done_o), .clr_o(clr),
      .chk_valid_o(chk_valid), .exp_o(exp_word), .pat_o(cur_pat), .run_o(cur_run)
   );

   srpt_checker #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_RUNS(NUM_RUNS), .CNT_W(CNT_W)
   ) u_chk (
      .clk(clk), .rst_n(rst_n), .clr_i(clr), .chk_valid_i(chk_valid),
      .exp_i(exp_word), .rdata_i(mem_rdata_i), .addr_i(mem_addr_o),
      .pat_i(cur_pat), .run_i(cur_run), .err_cnt_o(err_cnt_o), .fail_o(fail_o),
      .first_valid_o(first_valid_o), .first_addr_o(first_addr_o),
      .first_pat_o(first_pat_o), .first_run_o(first_run_o), .first_data_o(first_data_o)
   );
endmodule

// File: tb/sram_pattern_tester_bench.sv
module sram_pattern_tester_bench;
   localparam int BASE = 100;
   localparam int DONE_CYC = 1705;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        mem_ce, mem_we;
   logic [8:0]  mem_addr;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata = 32'hDEAD_BEEF;
   logic        busy, done, fail, first_valid;
   logic [47:0] err_cnt;
   logic [8:0]  first_addr;
   logic [2:0]  first_pat;
   logic [1:0]  first_run;
   logic [31:0] first_data;

   int checks = 0;
   int failures = 0;
   int cyc = 0;

   always #5 clk = ~clk;

   sram_pattern_tester #(.BASE_ADDR(BASE)) u_sram_pattern_tester (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .mem_ce_o(mem_ce), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
      .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
      .busy_o(busy), .done_o(done), .fail_o(fail), .err_cnt_o(err_cnt),
      .first_valid_o(first_valid), .first_addr_o(first_addr),
      .first_pat_o(first_pat), .first_run_o(first_run), .first_data_o(first_data)
   );

   // memory model: data launched on the falling edge after the read is captured
   logic [31:0] mem [0:511];
   logic        rd_pend = 1'b0;
   logic [8:0]  rd_addr = '0;
   int          rd_cnt = 0;
   int          rd_idx = 0;
   logic        stuck_en = 1'b0;
   logic [8:0]  stuck_addr = '0;
   logic [31:0] stuck_or = '0;
   logic        flip_en = 1'b0;
   int          flip_idx = 0;

   always @(posedge clk) begin
      rd_pend <= 1'b0;
      if (mem_ce && mem_we) mem[mem_addr] <= mem_wdata;
      if (mem_ce && !mem_we) begin
         rd_pend <= 1'b1;
         rd_addr <= mem_addr;
         rd_idx  <= rd_cnt;
         rd_cnt  <= rd_cnt + 1;
      end
   end

   always @(negedge clk) begin
      logic [31:0] w;
      if (rd_pend) begin
         w = mem[rd_addr];
         if (stuck_en && rd_addr == stuck_addr) w = w | stuck_or;
         if (flip_en && rd_idx == flip_idx) w = w ^ 32'h1;
         mem_rdata <= w;
      end else begin
         mem_rdata <= 32'hDEAD_BEEF;
      end
   end

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         checks++;
         failures++;
         $display("FAIL watchdog: run did not finish act=%0d exp<=150000", cyc);
         summary();
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] bg(input int idx);
      case (idx)
         0: return 32'h5555_5555;
         1: return 32'h3333_3333;
         2: return 32'h0F0F_0F0F;
         3: return 32'h00FF_00FF;
         4: return 32'h0000_FFFF;
         5: return 32'hFFFF_FFFF;
         default: return 32'h0000_0000;
      endcase
   endfunction

   function automatic logic [15:0] cnt_of(input int r);
      return err_cnt[r*16 +: 16];
   endfunction

   // raise start for one edge; returns at the negedge of the first working cycle
   task automatic start_pulse();
      @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic wait_done(output int n);
      n = 1;
      while (!done && n < 4000) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      check(mem_ce == 1'b0, "R1", "ce after reset", 64'(mem_ce), 0);
      check(mem_we == 1'b0, "R1", "we after reset", 64'(mem_we), 0);
      check(busy == 1'b0, "R1", "busy after reset", 64'(busy), 0);
      check(done == 1'b0, "R1", "done after reset", 64'(done), 0);
      check(fail == 1'b0 && first_valid == 1'b0, "R1", "fail/first after reset",
            64'({fail, first_valid}), 0);
      check(err_cnt == '0, "R1", "counters after reset", 64'(err_cnt), 0);
   endtask

   task automatic t_clean_stream();
      int bad_w = 0, bad_r = 0, bad_gap = 0;
      start_pulse();
      for (int run = 0; run < 3; run++) begin
         for (int p = 0; p < 7; p++) begin
            for (int w = 0; w < 16; w++) begin
               if (!(mem_ce && mem_we && mem_addr == 9'(BASE + w) && mem_wdata == bg(p)))
                  bad_w++;
               @(negedge clk);
            end
            for (int w = 0; w < 16; w++) begin
               for (int k = 0; k < 2; k++) begin
                  if (!(mem_ce && !mem_we && mem_addr == 9'(BASE + w))) bad_r++;
                  @(negedge clk);
                  if (mem_ce) bad_r++;
                  @(negedge clk);
               end
            end
            if (mem_ce) bad_gap++;
            @(negedge clk);
         end
         if (mem_ce) bad_gap++;
         @(negedge clk);
      end
      check(bad_w == 0, "R3", "write cycles wrong (R4 values)", 64'(bad_w), 0);
      check(bad_r == 0, "R5", "read cycles wrong", 64'(bad_r), 0);
      check(bad_gap == 0, "R6", "gap cycles with ce", 64'(bad_gap), 0);
      check(done == 1'b1, "R6", "done at cycle 1705", 64'(done), 1);
      check(err_cnt == '0 && fail == 1'b0, "R7", "clean run counts",
            64'(err_cnt), 0);
      check(first_valid == 1'b0, "R9", "no first record on clean run",
            64'(first_valid), 0);
      @(negedge clk);
      check(done == 1'b0 && busy == 1'b0, "R6", "done one cycle then idle",
            64'({done, busy}), 0);
   endtask

   task automatic t_stuck_bit();
      int n;
      stuck_en = 1'b1;
      stuck_addr = 9'(BASE + 5);
      stuck_or = 32'h8000_0000;
      start_pulse();
      wait_done(n);
      check(n == DONE_CYC, "R6", "stuck test length", 64'(n), 64'(DONE_CYC));
      for (int r = 0; r < 3; r++)
         check(cnt_of(r) == 16'd12, "R7", $sformatf("run %0d count stuck", r),
               64'(cnt_of(r)), 12);
      check(fail == 1'b1, "R8", "fail set", 64'(fail), 1);
      check(first_valid && first_addr == 9'(BASE + 5), "R9", "first addr",
            64'(first_addr), 64'(BASE + 5));
      check(first_pat == 3'd0 && first_run == 2'd0, "R9", "first pat/run not overwritten",
            64'({first_pat, first_run}), 0);
      check(first_data == 32'hD555_5555, "R9", "first data", 64'(first_data),
            64'h D555_5555);
      repeat (20) @(negedge clk);
      check(cnt_of(2) == 16'd12 && fail, "R7", "counts held after done",
            64'(cnt_of(2)), 12);
      stuck_en = 1'b0;
   endtask

   task automatic t_restart_clear();
      int n;
      start_pulse();
      check(err_cnt == '0, "R7", "counters cleared on start", 64'(err_cnt), 0);
      check(fail == 1'b0, "R8", "fail cleared on start", 64'(fail), 0);
      check(first_valid == 1'b0, "R9", "first cleared on start", 64'(first_valid), 0);
      wait_done(n);
      check(err_cnt == '0 && !fail, "R8", "clean rerun results", 64'(err_cnt), 0);
      @(negedge clk);
   endtask

   task automatic t_transient();
      int n;
      flip_idx = rd_cnt + 327;
      flip_en = 1'b1;
      start_pulse();
      wait_done(n);
      check(cnt_of(0) == 16'd0, "R7", "transient run0", 64'(cnt_of(0)), 0);
      check(cnt_of(1) == 16'd1, "R7", "transient run1", 64'(cnt_of(1)), 1);
      check(cnt_of(2) == 16'd0, "R7", "transient run2", 64'(cnt_of(2)), 0);
      check(first_run == 2'd1 && first_pat == 3'd3, "R9", "transient run/pat",
            64'({first_run, first_pat}), 64'({2'd1, 3'd3}));
      check(first_addr == 9'(BASE + 3), "R9", "transient addr", 64'(first_addr),
            64'(BASE + 3));
      check(first_data == 32'h00FF_00FE, "R9", "transient data", 64'(first_data),
            64'h00FF_00FE);
      check(fail == 1'b1, "R8", "fail after transient", 64'(fail), 1);
      flip_en = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_busy_start();
      int n = 1;
      start_pulse();
      repeat (499) begin
         @(negedge clk);
         n++;
      end
      start_i = 1'b1;
      repeat (3) begin
         @(negedge clk);
         n++;
      end
      start_i = 1'b0;
      while (!done && n < 4000) begin
         @(negedge clk);
         n++;
      end
      check(n == DONE_CYC, "R2", "start while busy ignored", 64'(n), 64'(DONE_CYC));
      check(err_cnt == '0, "R2", "no disturbance from late start", 64'(err_cnt), 0);
      @(negedge clk);
      check(busy == 1'b0, "R2", "idle after test", 64'(busy), 0);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_clean_stream();
      t_stuck_bit();
      t_restart_clear();
      t_transient();
      t_busy_start();
      summary();
      $finish;
   end
endmodule